// File: doc/BRIEF.md
# Dual-Port Table Access Arbiter

This block sits in front of a single shared internal table and decides, cycle by cycle, which of two requesters may use it. One requester is a synchronous data-input port that holds a request with its operation fields until it sees its ready output high. The other is a processor register port whose cycles are framed by an active-low chip select that may toggle with no relation to the clock. The block presents at most one table operation per cycle and reports acceptance back to the requester that won.

After reset is released, the table needs a long initialisation. The block keeps both ready outputs low for a programmable number of cycles. Requests that arrive during this time are held, not discarded, and are served once initialisation ends. When both ports want the table in the same cycle, a priority input picks the winner. The losing port waits without an acceptance until it is served.

The chip select is brought into the clock domain through a synchroniser. A processor read is raised when the synchronised select falls. A processor write is raised when it rises, so that write is committed by the end of the cycle.

Top module: `dual_port_arbiter`

## Requirements
- R1: While rst_ni is low, din_rdy_o, proc_rdy_o and tbl_req_o are 0 and proc_rdata_o is 0.
- R2: After rst_ni is released, no table operation is issued and both ready outputs stay 0 for INIT_CYCLES clock edges. With a request already waiting, the first acceptance is visible in the cycle after the INIT_CYCLES-th edge.
- R3: A processor request made during initialisation stays pending. It is served after initialisation, once the data-input port no longer blocks it.
- R4: din_rdy_o is 1 in exactly the cycle in which the data-input operation is presented on the table outputs. In that cycle tbl_we_o, tbl_addr_o and tbl_wdata_o equal din_we_i, din_addr_i and din_wdata_i, and the operation takes effect at the following clock edge.
- R5: When both ports request in the same cycle, prio_din_i=1 gives that cycle to the data-input port and prio_din_i=0 gives it to the processor. At most one operation is issued per cycle.
- R6: The losing port gets no acceptance in the contended cycle. It is served in the first cycle in which the other port no longer requests.
- R7: A processor read (prw_i=1 while pcs_ni falls) with no contention sets proc_rdy_o for one cycle, 4 clock edges after the edge that first samples pcs_ni low. proc_rdata_o then holds the table word at paddr_i.
- R8: A processor write (prw_i=0 while pcs_ni falls) writes pdata_i to paddr_i, sampled after the synchronised rise of pcs_ni. With no contention, proc_rdy_o pulses 4 edges after the edge that first samples pcs_ni high. No write or acknowledge occurs while pcs_ni stays low.
- R9: Read operations from either port leave the table contents unchanged.
- R10: proc_rdata_o changes only together with a processor acknowledge. A processor write leaves it at the value of the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prio_din_i | input | 1 | 1: data-input port wins ties, 0: processor wins |
| din_req_i | input | 1 | Data-input operation request, held until accepted |
| din_we_i | input | 1 | Data-input operation is a write |
| din_addr_i | input | ADDR_W | Data-input table address |
| din_wdata_i | input | DATA_W | Data-input write data |
| din_rdy_o | output | 1 | Data-input operation accepted this cycle |
| pcs_ni | input | 1 | Processor chip select, active low, asynchronous |
| prw_i | input | 1 | Processor direction, 1 read, 0 write |
| paddr_i | input | ADDR_W | Processor table address |
| pdata_i | input | DATA_W | Processor write data |
| proc_rdata_o | output | DATA_W | Processor read data |
| proc_rdy_o | output | 1 | Processor read data available or write accepted |
| tbl_req_o | output | 1 | Table operation this cycle |
| tbl_we_o | output | 1 | Table operation is a write |
| tbl_addr_o | output | ADDR_W | Table address |
| tbl_wdata_o | output | DATA_W | Table write data |
| tbl_rdata_i | input | DATA_W | Table read data for tbl_addr_o, same cycle |

## Verification
The hardest situation to reach is an exact same-cycle collision between a data-input request and a processor request. The processor request only becomes visible after the chip select has crossed the synchroniser and its edge has been detected. The bench starts a processor read and then raises the data-input request at a sweep of offsets around the processor's arrival cycle, for both priority settings. It compares the acceptance cycle of each port with values worked out from the three-edge processor path. A second collision is built into the long initialisation window, where both ports are made to wait together for the first usable cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DIN  = 2'd1,
    SRC_PROC = 2'd2
  } src_e;
endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int unsigned INIT_CYCLES = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  generate
    if (INIT_CYCLES == 0) begin : g_none
      assign done_o = 1'b1;
    end else begin : g_cnt
      localparam int unsigned CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
      localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);
      logic [CW-1:0] cnt_q;
      logic          done_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          done_q <= 1'b0;
        end else if (!done_q) begin
          if (cnt_q == LAST) done_q <= 1'b1;
          else               cnt_q  <= cnt_q + 1'b1;
        end
      end
      assign done_o = done_q;

      assert_done_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_q |=> done_q);
    end
  endgenerate
endmodule

// File: rtl/proc_front.sv
module proc_front #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pcs_ni,
  input  logic              prw_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic              gnt_i,
  output logic              pend_o,
  output logic              pend_we_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [DATA_W-1:0] pend_data_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cs_s, cs_d;
  logic                   fall, rise;
  logic                   cyc_rd_q;

  generate
    if (SYNC_STAGES == 1) begin : g_s1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= pcs_ni;
      end
    end else begin : g_sn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pcs_ni};
      end
    end
  endgenerate

  assign cs_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_d <= 1'b1;
    else         cs_d <= cs_s;
  end

  assign fall = cs_d & ~cs_s;
  assign rise = ~cs_d & cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cyc_rd_q <= 1'b1;
    else if (fall) cyc_rd_q <= prw_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o      <= 1'b0;
      pend_we_o   <= 1'b0;
      pend_addr_o <= '0;
      pend_data_o <= '0;
    end else begin
      if (gnt_i) pend_o <= 1'b0;
      if (fall && prw_i) begin
        pend_o      <= 1'b1;
        pend_we_o   <= 1'b0;
        pend_addr_o <= paddr_i;
      end else if (rise && !cyc_rd_q) begin
        pend_o      <= 1'b1;
        pend_we_o   <= 1'b1;
        pend_addr_o <= paddr_i;
        pend_data_o <= pdata_i;
      end
    end
  end

  assert_pend_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !gnt_i |=> pend_o);
  assert_no_write_while_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s && $past(!cs_s) |-> !(pend_o && pend_we_o && !$past(pend_o)));
endmodule

// File: rtl/arb_core.sv
module arb_core
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic              prio_din_i,
  input  logic              din_req_i,
  input  logic              din_we_i,
  input  logic [ADDR_W-1:0] din_addr_i,
  input  logic [DATA_W-1:0] din_wdata_i,
  input  logic              proc_pend_i,
  input  logic              proc_we_i,
  input  logic [ADDR_W-1:0] proc_addr_i,
  input  logic [DATA_W-1:0] proc_wdata_i,
  input  logic [DATA_W-1:0] tbl_rdata_i,
  output logic              din_gnt_o,
  output logic              proc_gnt_o,
  output logic              tbl_req_o,
  output logic              tbl_we_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic [DATA_W-1:0] tbl_wdata_o,
  output logic              proc_rdy_o,
  output logic [DATA_W-1:0] proc_rdata_o
);
  src_e sel;

  always_comb begin
    sel = SRC_NONE;
    if (init_done_i) begin
      if (din_req_i && proc_pend_i) sel = prio_din_i ? SRC_DIN : SRC_PROC;
      else if (din_req_i)           sel = SRC_DIN;
      else if (proc_pend_i)         sel = SRC_PROC;
    end
  end

  assign din_gnt_o  = (sel == SRC_DIN);
  assign proc_gnt_o = (sel == SRC_PROC);

  always_comb begin
    tbl_req_o   = 1'b0;
    tbl_we_o    = 1'b0;
    tbl_addr_o  = '0;
    tbl_wdata_o = '0;
    case (sel)
      SRC_DIN: begin
        tbl_req_o   = 1'b1;
        tbl_we_o    = din_we_i;
        tbl_addr_o  = din_addr_i;
        tbl_wdata_o = din_wdata_i;
      end
      SRC_PROC: begin
        tbl_req_o   = 1'b1;
        tbl_we_o    = proc_we_i;
        tbl_addr_o  = proc_addr_i;
        tbl_wdata_o = proc_wdata_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      proc_rdy_o   <= 1'b0;
      proc_rdata_o <= '0;
    end else begin
      proc_rdy_o <= proc_gnt_o;
      if (proc_gnt_o && !proc_we_i) proc_rdata_o <= tbl_rdata_i;
    end
  end

  assert_one_op_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({din_gnt_o, proc_gnt_o}));
  assert_rdata_with_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(proc_rdata_o) |-> proc_rdy_o);
  assert_loser_waits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_pend_i && din_gnt_o |=> proc_pend_i);
endmodule

// File: rtl/dual_port_arbiter.sv
module dual_port_arbiter #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned INIT_CYCLES = 800,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prio_din_i,
  input  logic              din_req_i,
  input  logic              din_we_i,
  input  logic [ADDR_W-1:0] din_addr_i,
  input  logic [DATA_W-1:0] din_wdata_i,
  output logic              din_rdy_o,
  input  logic              pcs_ni,
  input  logic              prw_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pdata_i,
  output logic [DATA_W-1:0] proc_rdata_o,
  output logic              proc_rdy_o,
  output logic              tbl_req_o,
  output logic              tbl_we_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic [DATA_W-1:0] tbl_wdata_o,
  input  logic [DATA_W-1:0] tbl_rdata_i
);
  logic              init_done;
  logic              proc_gnt;
  logic              pend;
  logic              pend_we;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (init_done)
  );

  proc_front #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pcs_ni      (pcs_ni),
    .prw_i       (prw_i),
    .paddr_i     (paddr_i),
    .pdata_i     (pdata_i),
    .gnt_i       (proc_gnt),
    .pend_o      (pend),
    .pend_we_o   (pend_we),
    .pend_addr_o (pend_addr),
    .pend_data_o (pend_data)
  );

  arb_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_done_i  (init_done),
    .prio_din_i   (prio_din_i),
    .din_req_i    (din_req_i),
    .din_we_i     (din_we_i),
    .din_addr_i   (din_addr_i),
    .din_wdata_i  (din_wdata_i),
    .proc_pend_i  (pend),
    .proc_we_i    (pend_we),
    .proc_addr_i  (pend_addr),
    .proc_wdata_i (pend_data),
    .tbl_rdata_i  (tbl_rdata_i),
    .din_gnt_o    (din_rdy_o),
    .proc_gnt_o   (proc_gnt),
    .tbl_req_o    (tbl_req_o),
    .tbl_we_o     (tbl_we_o),
    .tbl_addr_o   (tbl_addr_o),
    .tbl_wdata_o  (tbl_wdata_o),
    .proc_rdy_o   (proc_rdy_o),
    .proc_rdata_o (proc_rdata_o)
  );

  assert_init_block_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done |-> !tbl_req_o && !din_rdy_o && !proc_rdy_o);
  assert_tie_prio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_rdy_o |-> !$past(prio_din_i && din_req_i));
  assert_din_fields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_rdy_o |-> tbl_req_o && tbl_we_o == din_we_i && tbl_addr_o == din_addr_i);
endmodule

// File: tb/tb_dual_port_arbiter.sv
module tb_dual_port_arbiter;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int INIT = 800;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          prio_din = 1'b1;
  logic          din_req = 1'b0, din_we = 1'b0;
  logic [AW-1:0] din_addr = '0;
  logic [DW-1:0] din_wdata = '0;
  logic          din_rdy;
  logic          pcs_n = 1'b1, prw = 1'b1;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pdata = '0;
  logic [DW-1:0] proc_rdata;
  logic          proc_rdy;
  logic          tbl_req, tbl_we;
  logic [AW-1:0] tbl_addr;
  logic [DW-1:0] tbl_wdata, tbl_rdata;
  logic [DW-1:0] mem [256];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dual_port_arbiter #(.ADDR_W(AW), .DATA_W(DW), .INIT_CYCLES(INIT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .prio_din_i(prio_din),
    .din_req_i(din_req), .din_we_i(din_we), .din_addr_i(din_addr),
    .din_wdata_i(din_wdata), .din_rdy_o(din_rdy),
    .pcs_ni(pcs_n), .prw_i(prw), .paddr_i(paddr), .pdata_i(pdata),
    .proc_rdata_o(proc_rdata), .proc_rdy_o(proc_rdy),
    .tbl_req_o(tbl_req), .tbl_we_o(tbl_we), .tbl_addr_o(tbl_addr),
    .tbl_wdata_o(tbl_wdata), .tbl_rdata_i(tbl_rdata)
  );

  function automatic logic [DW-1:0] init_word(int a);
    return DW'(a * 16'h0101) ^ 16'h3c00;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
    end else if (tbl_req && tbl_we) begin
      mem[tbl_addr] <= tbl_wdata;
    end
  end
  assign tbl_rdata = mem[tbl_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive phase at posedge+1, sample phase at posedge+3
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic proc_op(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat, output logic [DW-1:0] rdat, output int early);
    lat = -1;
    early = 0;
    rdat = '0;
    pcs_n = 1'b0; prw = rd; paddr = a; pdata = d;
    if (!rd) begin
      for (int j = 1; j <= 8; j++) begin
        step(); settle();
        if (proc_rdy) early++;
      end
      step();
      pcs_n = 1'b1;
      settle();
    end
    for (int j = 1; j <= 20; j++) begin
      step(); settle();
      if (proc_rdy && lat < 0) begin
        lat = j;
        rdat = proc_rdata;
      end
    end
    if (rd) begin
      step();
      pcs_n = 1'b1;
      repeat (5) step();
    end
  endtask

  initial begin
    int din_seen, proc_seen, lat, early;
    logic [DW-1:0] rd, last_rd;

    // R1 reset state
    repeat (3) step();
    settle();
    chk(din_rdy == 0 && proc_rdy == 0 && tbl_req == 0, "R1 ready/req in reset",
        {din_rdy, proc_rdy, tbl_req}, 0);
    chk(proc_rdata == 0, "R1 rdata in reset", proc_rdata, 0);

    // R2/R3/R4: requests waiting through initialisation
    step();
    rst_ni = 1'b1;
    prio_din = 1'b1;
    din_req = 1'b1; din_we = 1'b1; din_addr = 8'd3; din_wdata = 16'ha5a5;
    din_seen = -1; proc_seen = -1;
    for (int c = 1; c <= 810; c++) begin
      step();
      if (c == 10) begin pcs_n = 1'b0; prw = 1'b1; paddr = 8'd5; end
      if (din_seen >= 0 && c == din_seen + 1) din_req = 1'b0;
      settle();
      if (din_req && din_rdy && din_seen < 0) begin
        din_seen = c;
        chk(tbl_we && tbl_addr == 8'd3 && tbl_wdata == 16'ha5a5, "R4 din fields on table",
            tbl_wdata, 16'ha5a5);
      end
      if (proc_rdy && proc_seen < 0) begin proc_seen = c; rd = proc_rdata; end
    end
    chk(din_seen == INIT, "R2 first din acceptance cycle", din_seen, INIT);
    chk(proc_seen == INIT + 2, "R3 pending read served after init", proc_seen, INIT + 2);
    chk(rd == init_word(5), "R3 R7 pending read data", rd, init_word(5));
    chk(mem[3] == 16'ha5a5, "R4 din write landed", mem[3], 16'ha5a5);
    last_rd = rd;
    step();
    pcs_n = 1'b1;
    repeat (5) step();

    // R8 write, R10 rdata unchanged by write
    proc_op(1'b0, 8'd20, 16'h1234, lat, rd, early);
    chk(early == 0, "R8 no ack while select low", early, 0);
    chk(lat == 4, "R8 write ack latency", lat, 4);
    chk(mem[20] == 16'h1234, "R8 write data", mem[20], 16'h1234);
    chk(proc_rdata == last_rd, "R10 rdata kept across write", proc_rdata, last_rd);

    // R7 reads over several addresses, including written ones
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] e;
      a = (k == 0) ? 8'd20 : (k == 1) ? 8'd3 : AW'(k * 37);
      e = (k == 0) ? 16'h1234 : (k == 1) ? 16'ha5a5 : init_word(k * 37);
      proc_op(1'b1, a, '0, lat, rd, early);
      chk(lat == 4 && rd == e, "R7 read latency/data", rd, e);
    end

    // R5/R6 collision sweep, both priorities, din offsets 0..5 vs proc at cycle 3
    for (int p = 0; p < 2; p++) begin
      for (int o = 0; o <= 5; o++) begin
        int dg, pr, exp_d, exp_p;
        prio_din = p[0];
        din_we = 1'b0; din_addr = 8'd9;
        dg = -1; pr = -1;
        pcs_n = 1'b0; prw = 1'b1; paddr = 8'd7;
        if (o == 0) din_req = 1'b1;
        settle();
        if (din_req && din_rdy && dg < 0) dg = 0;
        for (int j = 1; j <= 12; j++) begin
          step();
          if (j == o) din_req = 1'b1;
          if (dg >= 0 && j == dg + 1) din_req = 1'b0;
          settle();
          if (din_req && din_rdy && dg < 0) dg = j;
          if (proc_rdy && pr < 0) pr = j;
        end
        exp_d = (o == 3 && p == 0) ? 4 : o;
        exp_p = ((o == 3 && p == 1) ? 4 : 3) + 1;
        chk(dg == exp_d, p ? "R5 din grant cycle prio_din=1" : "R6 din grant cycle prio_din=0",
            dg, exp_d);
        chk(pr == exp_p, p ? "R6 proc ack cycle prio_din=1" : "R5 proc ack cycle prio_din=0",
            pr, exp_p);
        din_req = 1'b0;
        pcs_n = 1'b1;
        repeat (5) step();
      end
    end

    // R9 reads left table untouched
    chk(mem[7] == init_word(7), "R9 proc read no modify", mem[7], init_word(7));
    chk(mem[9] == init_word(9), "R9 din read no modify", mem[9], init_word(9));

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule